// File: doc/BRIEF.md
# Tagged Result-Bus Forwarding Unit

This block supplies source operands to the two instructions that sit in the register-read stage of a two-path pipeline. One path is even and one is odd. Execution units on each path take different numbers of cycles to finish, so a result may already be on a bus before it holds its final value. Each in-flight stage on each path drives a tagged result bus. A tag holds a write-enable flag, a destination register index, the producing unit number, the value, and the stage at which that value becomes valid.

For every source operand, the unit finds the youngest bus entry whose destination matches the operand's register index. If that entry is valid by now, its value is used. If the producer has not yet reached its ready stage, the operand is flagged as waiting so that stall logic elsewhere can hold issue. When nothing matches, the register-file read value passes through unchanged.

The three source operands of both instructions are resolved in parallel. The results are captured in an operand latch, which feeds the first execute stage on the next clock.

Top module: `fwd_unit`

## Requirements
- R1: While `rst_ni` is low, every operand value, waiting flag and unit number output is zero.
- R2: The outputs change only on a rising clock edge. They reflect the inputs sampled at that edge, so results appear one cycle after the inputs are presented.
- R3: A bus entry whose write-enable bit is 0 never matches, whatever its destination index.
- R4: When no bus entry matches an operand, its output value equals its register-file input, its waiting flag is 0 and its unit output is 0.
- R5: Bus entry e sits in execute stage s = e/2 + 1 (integer division, so stages 1 to 7). It is ready when s is greater than or equal to its 3-bit ready-stage tag. A ready match drives the entry's value and its 3-bit unit number to the operand outputs, with the waiting flag at 0.
- R6: A match that is not yet ready sets the waiting flag, drives an operand value of zero and reports the matched entry's unit number.
- R7: Among matches in different stages, the lowest stage number wins, even when it is not ready and an older match is ready.
- R8: Among two matches in the same stage, the odd-path entry (path bit 1) wins over the even-path entry.
- R9: An entry in the last stage (stage 7, the result heading to write-back this cycle) is forwarded like any other entry.
- R10: All six operands resolve independently in the same cycle. Bus entry e = 2*(s-1) + path occupies slice e of each bus port. Operand o = 3*path + k (k = 0..2 for the sources) occupies slice o of each operand port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 14 | Write-enable bit of each bus entry |
| bus_dst_i | input | 98 | 7-bit destination register index per entry |
| bus_unit_i | input | 42 | 3-bit producing unit number (1 to 7) per entry |
| bus_rdy_i | input | 42 | 3-bit stage at which each entry's value becomes valid |
| bus_data_i | input | 1792 | 128-bit result value per entry |
| src_idx_i | input | 42 | 7-bit source register index per operand |
| rf_data_i | input | 768 | 128-bit register-file read value per operand |
| opnd_data_o | output | 768 | Resolved 128-bit value per operand |
| opnd_wait_o | output | 6 | Per-operand flag: matching producer not yet ready |
| opnd_unit_o | output | 18 | Unit number of the chosen producer, 0 when taken from the register file |

## Verification
A fault in the match or priority logic shows up one clock after the bus pattern that triggers it. The symptom is a wrong value, a wrong unit number or a wrong waiting flag on the affected operand. The stimulus therefore places a ready entry and a not-ready entry for the same register in different stages, places matching entries side by side in one stage, and places entries whose write-enable bit is clear. With this stimulus, an inverted priority or a missing readiness check changes a visible output. Since each bus entry has its own value and unit number, the outputs identify exactly which entry was picked.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int unsigned FWD_PATHS = 2;

    typedef enum logic {
        PATH_EVEN = 1'b0,
        PATH_ODD  = 1'b1
    } fwd_path_e;
endpackage

// File: rtl/fwd_entry_hit.sv
module fwd_entry_hit #(
    parameter int REG_W     = 7,
    parameter int STG_W     = 3,
    parameter int STAGE_NUM = 1
) (
    input  logic             we_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [STG_W-1:0] rdy_i,
    input  logic [REG_W-1:0] src_i,
    output logic             hit_o,
    output logic             ready_o
);
    // A disabled entry can never match
    assign hit_o   = we_i && (dst_i == src_i);
    // Value is valid once the entry has reached its ready stage
    assign ready_o = (STG_W'(STAGE_NUM) >= rdy_i);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel #(
    parameter int NSTAGE = 7,
    parameter int REG_W  = 7,
    parameter int DATA_W = 128,
    parameter int UNIT_W = 3,
    parameter int STG_W  = 3
) (
    input  logic [REG_W-1:0]                     src_i,
    input  logic [DATA_W-1:0]                    rf_i,
    input  logic [2*NSTAGE-1:0]                  bus_we_i,
    input  logic [2*NSTAGE*REG_W-1:0]            bus_dst_i,
    input  logic [2*NSTAGE*UNIT_W-1:0]           bus_unit_i,
    input  logic [2*NSTAGE*STG_W-1:0]            bus_rdy_i,
    input  logic [2*NSTAGE*DATA_W-1:0]           bus_data_i,
    output logic [DATA_W-1:0]                    data_o,
    output logic                                 wait_o,
    output logic [UNIT_W-1:0]                    unit_o
);
    import fwd_pkg::*;

    localparam int NENT  = int'(FWD_PATHS) * NSTAGE;
    localparam int ENT_W = $clog2(NENT);

    logic [NENT-1:0]  hit;
    logic [NENT-1:0]  rdy_ok;
    logic             found;
    logic [ENT_W-1:0] sel;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        for (genvar p = 0; p < int'(FWD_PATHS); p++) begin : g_path
            localparam int E = s * int'(FWD_PATHS) + p;
            fwd_entry_hit #(
                .REG_W    (REG_W),
                .STG_W    (STG_W),
                .STAGE_NUM(s + 1)
            ) hit_i (
                .we_i   (bus_we_i[E]),
                .dst_i  (bus_dst_i[E*REG_W +: REG_W]),
                .rdy_i  (bus_rdy_i[E*STG_W +: STG_W]),
                .src_i  (src_i),
                .hit_o  (hit[E]),
                .ready_o(rdy_ok[E])
            );
        end
    end

    // Scan from oldest to youngest so the youngest hit is written last.
    // Within a stage the odd entry is visited after the even entry.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = NENT - 1; k >= 0; k--) begin
            if (hit[(k / 2) * 2 + 1 - (k % 2)]) begin
                found = 1'b1;
                sel   = ENT_W'((k / 2) * 2 + 1 - (k % 2));
            end
        end
    end

    always_comb begin
        wait_o = found && !rdy_ok[sel];
        unit_o = found ? bus_unit_i[int'(sel)*UNIT_W +: UNIT_W] : '0;
        if (!found) begin
            data_o = rf_i;
        end else if (rdy_ok[sel]) begin
            data_o = bus_data_i[int'(sel)*DATA_W +: DATA_W];
        end else begin
            data_o = '0;
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
    parameter int NSTAGE  = 7,
    parameter int NUM_SRC = 3,
    parameter int REG_W   = 7,
    parameter int DATA_W  = 128,
    parameter int UNIT_W  = 3,
    parameter int STG_W   = $clog2(NSTAGE + 1),
    parameter int NENT    = 2 * NSTAGE,
    parameter int NOPND   = 2 * NUM_SRC
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NENT-1:0]           bus_we_i,
    input  logic [NENT*REG_W-1:0]     bus_dst_i,
    input  logic [NENT*UNIT_W-1:0]    bus_unit_i,
    input  logic [NENT*STG_W-1:0]     bus_rdy_i,
    input  logic [NENT*DATA_W-1:0]    bus_data_i,
    input  logic [NOPND*REG_W-1:0]    src_idx_i,
    input  logic [NOPND*DATA_W-1:0]   rf_data_i,
    output logic [NOPND*DATA_W-1:0]   opnd_data_o,
    output logic [NOPND-1:0]          opnd_wait_o,
    output logic [NOPND*UNIT_W-1:0]   opnd_unit_o
);
    typedef struct packed {
        logic [NOPND-1:0][DATA_W-1:0] data;
        logic [NOPND-1:0]             wait_f;
        logic [NOPND-1:0][UNIT_W-1:0] unit;
    } opnd_latch_t;

    logic [NOPND-1:0][DATA_W-1:0] sel_data;
    logic [NOPND-1:0]             sel_wait;
    logic [NOPND-1:0][UNIT_W-1:0] sel_unit;

    opnd_latch_t latch_d, latch_q;

    for (genvar o = 0; o < NOPND; o++) begin : g_opnd
        fwd_operand_sel #(
            .NSTAGE(NSTAGE),
            .REG_W (REG_W),
            .DATA_W(DATA_W),
            .UNIT_W(UNIT_W),
            .STG_W (STG_W)
        ) sel_i (
            .src_i     (src_idx_i[o*REG_W +: REG_W]),
            .rf_i      (rf_data_i[o*DATA_W +: DATA_W]),
            .bus_we_i  (bus_we_i),
            .bus_dst_i (bus_dst_i),
            .bus_unit_i(bus_unit_i),
            .bus_rdy_i (bus_rdy_i),
            .bus_data_i(bus_data_i),
            .data_o    (sel_data[o]),
            .wait_o    (sel_wait[o]),
            .unit_o    (sel_unit[o])
        );
    end

    always_comb begin
        latch_d        = latch_q;
        latch_d.data   = sel_data;
        latch_d.wait_f = sel_wait;
        latch_d.unit   = sel_unit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    assign opnd_data_o = latch_q.data;
    assign opnd_wait_o = latch_q.wait_f;
    assign opnd_unit_o = latch_q.unit;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int NSTAGE  = 7,
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 128,
    parameter int UNIT_W  = 3,
    parameter int STG_W   = $clog2(NSTAGE + 1),
    parameter int NENT    = 2 * NSTAGE,
    parameter int NOPND   = 2 * NUM_SRC
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [NENT-1:0]         bus_we_i,
    input logic [NENT*STG_W-1:0]   bus_rdy_i,
    input logic [NOPND*DATA_W-1:0] rf_data_i,
    input logic [NOPND*DATA_W-1:0] opnd_data_o,
    input logic [NOPND-1:0]        opnd_wait_o,
    input logic [NOPND*UNIT_W-1:0] opnd_unit_o
);
    logic all_early;

    always_comb begin
        all_early = 1'b1;
        for (int e = 0; e < NENT; e++) begin
            if (bus_rdy_i[e*STG_W +: STG_W] > STG_W'(1)) all_early = 1'b0;
        end
    end

    AST_RST_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |=> (opnd_wait_o == '0 && opnd_unit_o == '0 && opnd_data_o == '0)); // R1

    AST_IDLE_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i == '0) |=> (opnd_wait_o == '0 && opnd_unit_o == '0)); // R3

    AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i == '0) |=> (opnd_data_o == $past(rf_data_i))); // R4

    AST_ALL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_early |=> (opnd_wait_o == '0)); // R5

    for (genvar o = 0; o < NOPND; o++) begin : g_wait
        AST_WAIT_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
            opnd_wait_o[o] |-> (opnd_data_o[o*DATA_W +: DATA_W] == '0)); // R6
    end
endmodule

bind fwd_unit fwd_unit_chk #(
    .NSTAGE (NSTAGE),
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W),
    .UNIT_W (UNIT_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_rdy_i  (bus_rdy_i),
    .rf_data_i  (rf_data_i),
    .opnd_data_o(opnd_data_o),
    .opnd_wait_o(opnd_wait_o),
    .opnd_unit_o(opnd_unit_o)
);

// File: tb/fwd_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_unit_tb_top;
    localparam int NSTAGE = 7;
    localparam int NENT   = 14;
    localparam int NOPND  = 6;
    localparam int REG_W  = 7;
    localparam int DATA_W = 128;
    localparam int UNIT_W = 3;
    localparam int STG_W  = 3;
    localparam int NVEC   = 12;

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] a_stg; logic a_p; logic [6:0] a_dst; logic [2:0] a_rdy; logic a_we;
        logic [2:0] b_stg; logic b_p; logic [6:0] b_dst; logic [2:0] b_rdy; logic b_we;
        logic [6:0] src;
        logic [3:0] code;   // 0: register file, else chosen entry + 1
        logic       wt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd4, 3'd1,1'b0,7'd5,  3'd1,1'b0, 3'd1,1'b0,7'd5,  3'd1,1'b0, 7'd5,  4'd0,  1'b0}, // R4
        '{4'd5, 3'd3,1'b0,7'd5,  3'd1,1'b1, 3'd1,1'b0,7'd5,  3'd1,1'b0, 7'd5,  4'd5,  1'b0}, // R5
        '{4'd3, 3'd3,1'b0,7'd5,  3'd1,1'b0, 3'd1,1'b0,7'd5,  3'd1,1'b0, 7'd5,  4'd0,  1'b0}, // R3
        '{4'd6, 3'd2,1'b0,7'd9,  3'd7,1'b1, 3'd1,1'b0,7'd9,  3'd1,1'b0, 7'd9,  4'd3,  1'b1}, // R6
        '{4'd7, 3'd5,1'b0,7'd9,  3'd3,1'b1, 3'd2,1'b1,7'd9,  3'd6,1'b1, 7'd9,  4'd4,  1'b1}, // R7
        '{4'd8, 3'd4,1'b0,7'd12, 3'd2,1'b1, 3'd4,1'b1,7'd12, 3'd2,1'b1, 7'd12, 4'd8,  1'b0}, // R8
        '{4'd9, 3'd7,1'b1,7'd127,3'd7,1'b1, 3'd1,1'b0,7'd0,  3'd1,1'b0, 7'd127,4'd14, 1'b0}, // R9
        '{4'd7, 3'd1,1'b0,7'd3,  3'd1,1'b1, 3'd6,1'b1,7'd3,  3'd1,1'b1, 7'd3,  4'd1,  1'b0}, // R7
        '{4'd4, 3'd1,1'b0,7'd4,  3'd1,1'b1, 3'd1,1'b0,7'd4,  3'd1,1'b0, 7'd3,  4'd0,  1'b0}, // R4
        '{4'd5, 3'd6,1'b0,7'd0,  3'd6,1'b1, 3'd1,1'b0,7'd0,  3'd1,1'b0, 7'd0,  4'd11, 1'b0}, // R5
        '{4'd6, 3'd6,1'b0,7'd0,  3'd7,1'b1, 3'd1,1'b0,7'd0,  3'd1,1'b0, 7'd0,  4'd11, 1'b1}, // R6
        '{4'd3, 3'd1,1'b0,7'd8,  3'd1,1'b0, 3'd4,1'b1,7'd8,  3'd1,1'b1, 7'd8,  4'd8,  1'b0}  // R3
    };

    logic                     clk_i = 1'b0;
    logic                     rst_ni = 1'b0;
    logic [NENT-1:0]          bus_we_i = '0;
    logic [NENT*REG_W-1:0]    bus_dst_i = '0;
    logic [NENT*UNIT_W-1:0]   bus_unit_i = '0;
    logic [NENT*STG_W-1:0]    bus_rdy_i = '0;
    logic [NENT*DATA_W-1:0]   bus_data_i = '0;
    logic [NOPND*REG_W-1:0]   src_idx_i = '0;
    logic [NOPND*DATA_W-1:0]  rf_data_i = '0;
    logic [NOPND*DATA_W-1:0]  opnd_data_o;
    logic [NOPND-1:0]         opnd_wait_o;
    logic [NOPND*UNIT_W-1:0]  opnd_unit_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    fwd_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_we_i(bus_we_i), .bus_dst_i(bus_dst_i), .bus_unit_i(bus_unit_i),
        .bus_rdy_i(bus_rdy_i), .bus_data_i(bus_data_i),
        .src_idx_i(src_idx_i), .rf_data_i(rf_data_i),
        .opnd_data_o(opnd_data_o), .opnd_wait_o(opnd_wait_o), .opnd_unit_o(opnd_unit_o)
    );

    function automatic logic [DATA_W-1:0] ent_val(input int e);
        return {16{8'(8'hA0 + e)}};
    endfunction
    function automatic logic [UNIT_W-1:0] ent_unit(input int e);
        return UNIT_W'((e % 7) + 1);
    endfunction
    function automatic logic [DATA_W-1:0] rf_val(input int o);
        return {16{8'(8'h10 + o)}};
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill the bus: every slot is disabled but points at src_all
    task automatic bus_blank(input logic [6:0] src_all);
        for (int e = 0; e < NENT; e++) begin
            bus_we_i[e] = 1'b0;
            bus_dst_i[e*REG_W +: REG_W]      = src_all;
            bus_rdy_i[e*STG_W +: STG_W]      = 3'd1;
            bus_unit_i[e*UNIT_W +: UNIT_W]   = ent_unit(e);
            bus_data_i[e*DATA_W +: DATA_W]   = ent_val(e);
        end
        for (int o = 0; o < NOPND; o++) begin
            src_idx_i[o*REG_W +: REG_W]  = src_all;
            rf_data_i[o*DATA_W +: DATA_W] = rf_val(o);
        end
    endtask

    task automatic place(input logic [2:0] stg, input logic p, input logic [6:0] dst,
                         input logic [2:0] rdy, input logic we);
        int e;
        e = 2 * (int'(stg) - 1) + int'(p);
        bus_we_i[e] = we;
        bus_dst_i[e*REG_W +: REG_W] = dst;
        bus_rdy_i[e*STG_W +: STG_W] = rdy;
    endtask

    task automatic check_opnd(input string req, input int o, input int code, input logic wt);
        logic [DATA_W-1:0] ed;
        logic [UNIT_W-1:0] eu;
        ed = (code == 0) ? rf_val(o) : (wt ? '0 : ent_val(code - 1));
        eu = (code == 0) ? '0 : ent_unit(code - 1);
        check(req, opnd_data_o[o*DATA_W +: DATA_W], ed);
        check(req, DATA_W'(opnd_wait_o[o]), DATA_W'(wt));
        check(req, DATA_W'(opnd_unit_o[o*UNIT_W +: UNIT_W]), DATA_W'(eu));
    endtask

    initial begin
        // R1: outputs stay zero under reset even with a live matching bus
        bus_blank(7'd5);
        place(3'd1, 1'b0, 7'd5, 3'd1, 1'b1);
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        for (int o = 0; o < NOPND; o++) begin
            check("R1", opnd_data_o[o*DATA_W +: DATA_W], '0);
            check("R1", DATA_W'(opnd_wait_o[o]), '0);
            check("R1", DATA_W'(opnd_unit_o[o*UNIT_W +: UNIT_W]), '0);
        end
        rst_ni = 1'b1;

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            bus_blank(VECS[v].src);
            place(VECS[v].a_stg, VECS[v].a_p, VECS[v].a_dst, VECS[v].a_rdy, VECS[v].a_we);
            place(VECS[v].b_stg, VECS[v].b_p, VECS[v].b_dst, VECS[v].b_rdy, VECS[v].b_we);
            @(posedge clk_i);
            @(negedge clk_i);
            for (int o = 0; o < NOPND; o++) check_opnd(tag, o, int'(VECS[v].code), VECS[v].wt);
        end

        // R2: a new pattern shows nothing until the next edge
        bus_blank(7'd9);
        place(3'd2, 1'b0, 7'd9, 3'd7, 1'b1);
        @(posedge clk_i);
        @(negedge clk_i);
        bus_blank(7'd9);
        #1;
        check("R2", DATA_W'(opnd_wait_o), DATA_W'(6'h3F));
        @(posedge clk_i);
        @(negedge clk_i);
        check("R2", DATA_W'(opnd_wait_o), '0);

        // R10: each operand names its own register, held by its own entry
        bus_blank(7'd0);
        for (int o = 0; o < NOPND; o++) begin
            src_idx_i[o*REG_W +: REG_W] = 7'(20 + o);
            place(3'(o + 1), 1'b0, 7'(20 + o), 3'(o + 1), 1'b1);
        end
        @(posedge clk_i);
        @(negedge clk_i);
        for (int o = 0; o < NOPND; o++) check_opnd("R10", o, 2 * o + 1, 1'b0);

        // R1: reset asserted mid-run clears the latch
        rst_ni = 1'b0;
        #1;
        check("R1", DATA_W'(opnd_unit_o), '0);
        check("R1", opnd_data_o[DATA_W-1:0], '0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule